// File: doc/BRIEF.md
# Falling-Edge Delay Prescaler and Step Solver

The solver turns a requested delay in nanoseconds into the two settings of a delay line that is counted in steps of a 40 ns base tick. One setting is a 7-bit prescaler `p`, which stretches each step to `(p+1)*40` ns. The other is a 4-bit step count `n`. The solver takes the smallest prescaler for which the rounded-up step count `ceil(delay / ((p+1)*40))` is no greater than 15. It reports that prescaler together with its step count.

A request is taken when the start strobe is high and the solver is idle. The solver then tries the prescaler candidates one per clock in rising order. A running limit of `15*(p+1)*40` tells it which candidate is the first to fit. Only that candidate goes to a short restoring divider, which computes the ceiling quotient over a few cycles. The solver ends with either a one-cycle `done_o` pulse or a one-cycle `err_o` pulse. `err_o` means that no candidate fits. A request of zero means the delay is switched off and resolves to the off setting. The delay hardware itself is written by other logic.

Top module: `dsolve_delay_solver`

## Requirements
- R1: After reset `prescale_o` and `steps_o` are 0, and `done_o` and `err_o` are low.
- R2: On `done_o` for a nonzero request, `steps_o` equals ceil(request / ((`prescale_o`+1)*40)), is at most 15, and `steps_o*(prescale_o+1)*40` is at least the request.
- R3: The reported `prescale_o` is the smallest value from 0 to 127 whose rounded-up step count is 15 or less. Requests up to 600 ns give prescaler 0, and 76800 ns gives prescaler 127 with 15 steps.
- R4: A request of 0 completes with `done_o` and sets `prescale_o` to 0 and `steps_o` to 0. A step count of 0 means the delay is off.
- R5: A request above 76800 ns does not fit any prescaler. It gives an `err_o` pulse without `done_o`, and `prescale_o` and `steps_o` keep their previous values.
- R6: `done_o` and `err_o` are each high for exactly one cycle, and they are never high together.
- R7: A start strobe that arrives while a search is running is ignored. The result belongs to the first request, and no second completion follows.
- R8: `prescale_o` and `steps_o` change only in the cycle where `done_o` is high, and otherwise hold their value.
- R9: `done_o` or `err_o` arrives no more than 2^7 + 4 + 3 = 135 clock cycles after the cycle in which the start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; taken only while idle |
| req_ns_i | input | 32 | Requested delay in nanoseconds |
| prescale_o | output | 7 | Prescaler setting; each step lasts (value+1)*40 ns |
| steps_o | output | 4 | Step count; 0 means the delay is off |
| done_o | output | 1 | One-cycle pulse when a setting has been produced |
| err_o | output | 1 | One-cycle pulse when no setting fits |

## Verification
The bench builds the block with its default parameters: a 32-bit request, a 7-bit prescaler, a 4-bit step count and a 40 ns base tick. With these values the 600 ns reach of each prescaler step and the 76800 ns top of the range are exact numbers that directed requests can land on, one nanosecond either side. This brings the full 128-candidate scan, the first and last candidates, and the overflow error within reach of short runs. A sweep of spaced requests is compared against an independent search that counts quotients upward.

// File: rtl/dsolve_pkg.sv
package dsolve_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DIV  = 2'd2
  } dsolve_state_e;

endpackage

// File: rtl/dsolve_scan.sv
module dsolve_scan #(
  parameter int PRE_W    = 7,
  parameter int ACC_W    = 33,
  parameter int UNIT_NS  = 40,
  parameter int STEP_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [PRE_W-1:0] idx_o,
  output logic [ACC_W-1:0] div_o,
  output logic [ACC_W-1:0] lim_o,
  output logic             last_o
);

  localparam logic [ACC_W-1:0] UNIT_A = ACC_W'(UNIT_NS);
  localparam logic [ACC_W-1:0] LIM_A  = ACC_W'(UNIT_NS * STEP_MAX);

  // Candidate divisor and fit limit move as two separate accumulators.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o <= '0;
      div_o <= UNIT_A;
      lim_o <= LIM_A;
    end else if (clear_i) begin
      idx_o <= '0;
      div_o <= UNIT_A;
      lim_o <= LIM_A;
    end else if (adv_i) begin
      idx_o <= idx_o + 1'b1;
      div_o <= div_o + UNIT_A;
      lim_o <= lim_o + LIM_A;
    end
  end

  assign last_o = (idx_o == {PRE_W{1'b1}});

  assert_limit_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lim_o == div_o * ACC_W'(STEP_MAX));

  assert_divisor_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_o == (ACC_W'(idx_o) + 1'b1) * UNIT_A);

endmodule

// File: rtl/dsolve_ceil_div.sv
module dsolve_ceil_div #(
  parameter int ACC_W = 33,
  parameter int Q_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ACC_W-1:0] num_i,
  input  logic [ACC_W-1:0] den_i,
  output logic [Q_W-1:0]   q_o,
  output logic             valid_o
);

  localparam int W     = ACC_W + Q_W;
  localparam int CNT_W = $clog2(Q_W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     dsh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] num_q;
  logic [ACC_W-1:0] den_q;
  logic             ge;

  // The quotient is known to be below 2^Q_W, so Q_W restoring steps suffice.
  assign ge = (rem_q >= dsh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      dsh_q   <= '0;
      cnt_q   <= '0;
      num_q   <= '0;
      den_q   <= '0;
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (load_i) begin
        rem_q <= W'(num_i) + W'(den_i) - 1'b1;
        dsh_q <= W'(den_i) << (Q_W - 1);
        cnt_q <= CNT_W'(Q_W);
        num_q <= num_i;
        den_q <= den_i;
        q_o   <= '0;
      end else if (cnt_q != '0) begin
        if (ge) rem_q <= rem_q - dsh_q;
        dsh_q <= dsh_q >> 1;
        q_o   <= {q_o[Q_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) valid_o <= 1'b1;
      end
    end
  end

  assert_ceil_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (W'(q_o) * W'(den_q) >= W'(num_q)));

  assert_ceil_tight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (W'(q_o) * W'(den_q) < W'(num_q) + W'(den_q)));

endmodule

// File: rtl/dsolve_delay_solver.sv
module dsolve_delay_solver #(
  parameter int REQ_W   = 32,
  parameter int PRE_W   = 7,
  parameter int STEP_W  = 4,
  parameter int UNIT_NS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REQ_W-1:0]  req_ns_i,
  output logic [PRE_W-1:0]  prescale_o,
  output logic [STEP_W-1:0] steps_o,
  output logic              done_o,
  output logic              err_o
);
  import dsolve_pkg::*;

  localparam int ACC_W    = REQ_W + 1;
  localparam int STEP_MAX = (1 << STEP_W) - 1;
  localparam int CHK_W    = ACC_W + PRE_W + STEP_W + 8;

  dsolve_state_e     state_q;
  logic [REQ_W-1:0]  req_q;
  logic [PRE_W-1:0]  idx;
  logic [ACC_W-1:0]  divisor;
  logic [ACC_W-1:0]  limit;
  logic              last_cand;
  logic [STEP_W-1:0] quot;
  logic              quot_valid;

  // Named events for the state machine and the assertions.
  logic accept_ev, zero_ev, fit_ev, miss_ev, adv_ev, busy;

  function automatic logic fits_limit(input logic [REQ_W-1:0] r,
                                      input logic [ACC_W-1:0] lim);
    return ACC_W'(r) <= lim;
  endfunction

  assign busy      = (state_q != ST_IDLE);
  assign accept_ev = start_i && !busy;
  assign zero_ev   = (state_q == ST_SCAN) && (req_q == '0);
  assign fit_ev    = (state_q == ST_SCAN) && !zero_ev && fits_limit(req_q, limit);
  assign miss_ev   = (state_q == ST_SCAN) && !zero_ev && !fit_ev && last_cand;
  assign adv_ev    = (state_q == ST_SCAN) && !zero_ev && !fit_ev && !last_cand;

  dsolve_scan #(
    .PRE_W(PRE_W), .ACC_W(ACC_W), .UNIT_NS(UNIT_NS), .STEP_MAX(STEP_MAX)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .clear_i(accept_ev), .adv_i(adv_ev),
    .idx_o(idx), .div_o(divisor), .lim_o(limit), .last_o(last_cand)
  );

  dsolve_ceil_div #(
    .ACC_W(ACC_W), .Q_W(STEP_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(fit_ev),
    .num_i(ACC_W'(req_q)), .den_i(divisor),
    .q_o(quot), .valid_o(quot_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      req_q      <= '0;
      prescale_o <= '0;
      steps_o    <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_ev) begin
          req_q   <= req_ns_i;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (zero_ev) begin
            prescale_o <= '0;
            steps_o    <= '0;
            done_o     <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (fit_ev) begin
            state_q <= ST_DIV;
          end else if (miss_ev) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DIV: if (quot_valid) begin
          prescale_o <= idx;
          steps_o    <= quot;
          done_o     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_result_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_q != '0) |->
      (CHK_W'(steps_o) * (CHK_W'(prescale_o) + 1'b1) * CHK_W'(UNIT_NS) >= CHK_W'(req_q)));

  assert_steps_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_q != '0) |-> (steps_o != '0));

  assert_smallest_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && prescale_o != '0) |->
      (CHK_W'(req_q) > CHK_W'(UNIT_NS * STEP_MAX) * CHK_W'(prescale_o)));

  assert_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_q == '0) |-> (steps_o == '0 && prescale_o == '0));

  assert_miss_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(prescale_o) && $stable(steps_o)));

  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(req_q));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(prescale_o) && $stable(steps_o)));

endmodule

// File: tb/dsolve_delay_solver_tb.sv
module dsolve_delay_solver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req = '0;
  logic [6:0]  pre;
  logic [3:0]  steps;
  logic        done;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;
  localparam int LAT_MAX = 135;

  always #4 clk = ~clk;  // 125 MHz

  dsolve_delay_solver u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_ns_i(req),
    .prescale_o(pre), .steps_o(steps), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Independent reference: count the quotient upward for each prescaler.
  task automatic ref_solve(input longint r, output bit fit, output int rp, output int rn);
    fit = 0; rp = 0; rn = 0;
    for (int p = 0; p < 128 && !fit; p++) begin
      longint d = longint'(p + 1) * 40;
      int q = 0;
      while (longint'(q) * d < r && q < 16) q++;
      if (q <= 15) begin fit = 1; rp = p; rn = q; end
    end
  endtask

  task automatic issue(input logic [31:0] r, output int lat, output bit gd, output bit ge);
    @(negedge clk); start = 1'b1; req = r;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!(done || err) && lat < 400) begin @(negedge clk); lat++; end
    gd = done; ge = err;
    @(negedge clk);
    check(!done && !err, "R6 pulse width", longint'(done) + longint'(err), 0);
  endtask

  task automatic t_reset();
    check(pre == 0, "R1 prescale", pre, 0);
    check(steps == 0, "R1 steps", steps, 0);
    check(!done && !err, "R1 pulses", longint'(done) + longint'(err), 0);
  endtask

  task automatic t_solve(input logic [31:0] r);
    int lat, rp, rn; bit gd, ge, fit;
    ref_solve(longint'(r), fit, rp, rn);
    issue(r, lat, gd, ge);
    check(lat <= LAT_MAX, "R9 latency", lat, LAT_MAX);
    if (fit) begin
      check(gd && !ge, "R6 done not err", longint'(ge), 0);
      check(int'(pre) == rp, $sformatf("R3 prescale req=%0d", r), pre, rp);
      check(int'(steps) == rn, $sformatf("R2 steps req=%0d", r), steps, rn);
    end else begin
      check(ge && !gd, $sformatf("R5 err req=%0d", r), longint'(ge), 1);
    end
  endtask

  task automatic t_miss(input logic [31:0] r);
    int lat; bit gd, ge;
    logic [6:0] p0; logic [3:0] s0;
    p0 = pre; s0 = steps;
    issue(r, lat, gd, ge);
    check(ge && !gd, $sformatf("R5 err req=%0d", r), longint'(ge), 1);
    check(pre == p0, "R5 prescale kept", pre, p0);
    check(steps == s0, "R5 steps kept", steps, s0);
    check(lat <= LAT_MAX, "R9 latency on miss", lat, LAT_MAX);
  endtask

  task automatic t_zero();
    int lat; bit gd, ge;
    issue(32'd0, lat, gd, ge);
    check(gd && !ge, "R4 zero done", longint'(gd), 1);
    check(pre == 0, "R4 zero prescale", pre, 0);
    check(steps == 0, "R4 zero steps", steps, 0);
  endtask

  task automatic t_busy();
    int lat = 0, extra = 0;
    @(negedge clk); start = 1'b1; req = 32'd601;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; req = 32'd40;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    check(pre == 1, "R7 first request prescale", pre, 1);
    check(steps == 8, "R7 first request steps", steps, 8);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done || err) extra++;
    end
    check(extra == 0, "R7 no second completion", extra, 0);
  endtask

  task automatic t_hold();
    logic [6:0] p0; logic [3:0] s0; int moved = 0;
    p0 = pre; s0 = steps;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pre != p0 || steps != s0) moved++;
    end
    check(moved == 0, "R8 outputs held", moved, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_solve(32'd1);
    t_solve(32'd40);
    t_solve(32'd41);
    t_solve(32'd600);
    t_solve(32'd601);
    t_hold();
    t_solve(32'd1200);
    t_solve(32'd1201);
    t_solve(32'd5000);
    t_solve(32'd76799);
    t_solve(32'd76800);
    check(pre == 127 && steps == 15, "R3 top of range", pre, 127);
    t_miss(32'd76801);
    t_miss(32'hFFFF_FFFF);
    t_zero();
    t_hold();
    t_busy();
    for (int k = 1; k <= 60; k++) t_solve(32'(k * 1279 + 7));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule